// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block is a master for a three-wire serial EEPROM that holds 128 bytes. A user port presents one command at a time: an operation code, a 7-bit byte address and a write byte. The controller turns the command into a serial frame and drives it on an active-high select, a serial clock and a data-out pin. For a read, it collects the returned byte from data-in. For any command that programs the array, it then polls the device until the device reports that it is ready.

The clock follows SPI mode 0. The clock rate comes from a divider on the system clock. The device presents read data half a bit period late, so the controller captures it on falling clock edges. After a program command the select line is dropped for a minimum gap and then raised again. Data-in is then watched until it goes high or a timeout expires. The two whole-array commands are accepted only when the high-voltage mode input is set. Each command finishes with a one-cycle done pulse that carries the read byte and an error code.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: The first part of each frame is 10 bits sent MSB first: a start bit of 1, a 2-bit opcode, then the 7-bit address. The opcode is `10` for read (op code 0), `01` for write (op 1) and `11` for erase (op 2).
- R2: The special commands send opcode `00`, and the top two address bits carry a sub-code: write-enable (op 3) sends `11`, write-disable (op 4) sends `00`, erase-all (op 5) sends `10` and write-all (op 6) sends `01`. The low five bits are zero. Erase-all and write-all with `hv_mode` low, and op 7 in any mode, end with done and err=2 (not supported) and never raise select.
- R3: Write and write-all send the 8-bit write byte MSB first, straight after the 10 frame bits, for a total of 18 clocks.
- R4: A read sends 8 more clocks after the frame. Data-in is sampled on each of their falling edges, MSB first, and the byte appears on `rdata` with done. Every other command returns `rdata`=0.
- R5: The serial clock idles low and pulses only while select is high. Data-out changes only while the clock is low. Select stays high through the whole frame.
- R6: Each clock high phase and each low phase inside a frame lasts HALF_DIV system clocks.
- R7: After a write, erase, erase-all or write-all frame, select stays low for at least GAP_CYC cycles. It is then raised and data-in is polled. When data-in is seen high, select drops and done reports err=0.
- R8: If data-in stays low for TIMEOUT_CYC cycles of polling, select drops and done reports err=1 (timeout).
- R9: `req_ready` is high only while the controller is idle and no done pulse is being shown. `done` is a single-cycle pulse. After reset, select and clock are low and `req_ready` is high.
- R10: Read, write-enable and write-disable raise select once and have no polling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Controller can accept a command |
| req_op | input | 3 | Operation code 0..6 (7 rejected) |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 8 | Byte for write and write-all |
| hv_mode | input | 1 | Permits the whole-array commands |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read, valid with done |
| err | output | 2 | 0 ok, 1 timeout, 2 not supported |
| mw_cs | output | 1 | Device select, active high |
| mw_sk | output | 1 | Serial clock |
| mw_do | output | 1 | Serial data to the device |
| mw_di | input | 1 | Serial data and ready from the device |

## Verification
Some rules hold on every cycle, and the assertions check them directly: the clock pulses only under select, data-out holds still while the clock is high, done lasts one cycle, select is released whenever done shows, the idle bus is quiet, and the divider ticks are spaced apart. Other properties can only be shown by the bench's scenarios. These are the frame bit patterns, the capture of read bytes on the late edge, the select gap before polling, the number of select windows per command, timeout versus ready, and the rejection of whole-array commands without high-voltage mode. A device model and a golden memory in the bench let these be compared.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WREN  = 3'd3,
    OP_WRDIS = 3'd4,
    OP_ERALL = 3'd5,
    OP_WRALL = 3'd6
  } mw_op_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_UNSUP   = 2'd2
  } mw_err_e;
endpackage

// File: rtl/mw_frame_enc.sv
module mw_frame_enc
  import mw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int HDR_BITS = 3 + ADDR_W,
  localparam int ALL_BITS = HDR_BITS + DATA_W,
  localparam int LEN_W = $clog2(ALL_BITS + 1)
) (
  input  logic [2:0]          op,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [ALL_BITS-1:0] frame,
  output logic [LEN_W-1:0]    nbits,
  output logic                is_rd,
  output logic                is_prog,
  output logic                hv_only,
  output logic                illegal
);
  localparam logic [ADDR_W-1:0] SUB_WREN  = ADDR_W'(2'b11) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] SUB_WRDIS = '0;
  localparam logic [ADDR_W-1:0] SUB_ERALL = ADDR_W'(2'b10) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] SUB_WRALL = ADDR_W'(2'b01) << (ADDR_W - 2);

  logic [HDR_BITS-1:0] hdr;
  logic [DATA_W-1:0]   dat;

  always_comb begin
    hdr     = '0;
    dat     = '0;
    nbits   = LEN_W'(HDR_BITS);
    is_rd   = 1'b0;
    is_prog = 1'b0;
    hv_only = 1'b0;
    illegal = 1'b0;
    case (mw_op_e'(op))
      OP_READ: begin
        hdr   = {1'b1, 2'b10, addr};
        nbits = LEN_W'(ALL_BITS);
        is_rd = 1'b1;
      end
      OP_WRITE: begin
        hdr     = {1'b1, 2'b01, addr};
        dat     = wdata;
        nbits   = LEN_W'(ALL_BITS);
        is_prog = 1'b1;
      end
      OP_ERASE: begin
        hdr     = {1'b1, 2'b11, addr};
        is_prog = 1'b1;
      end
      OP_WREN:  hdr = {1'b1, 2'b00, SUB_WREN};
      OP_WRDIS: hdr = {1'b1, 2'b00, SUB_WRDIS};
      OP_ERALL: begin
        hdr     = {1'b1, 2'b00, SUB_ERALL};
        is_prog = 1'b1;
        hv_only = 1'b1;
      end
      OP_WRALL: begin
        hdr     = {1'b1, 2'b00, SUB_WRALL};
        dat     = wdata;
        nbits   = LEN_W'(ALL_BITS);
        is_prog = 1'b1;
        hv_only = 1'b1;
      end
      default: illegal = 1'b1;
    endcase
    frame = {hdr, dat};
  end
endmodule

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
  parameter int HALF_DIV = 50,
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  generate
    if (HALF_DIV > 1) begin : g_spacing
      // R6: consecutive half-period strobes are never adjacent
      a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mw_wait_timer.sv
module mw_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || !en || clr) count <= '0;
    else                   count <= count + 1'b1;
  end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int HALF_DIV    = 50,
  parameter int GAP_CYC     = 25,
  parameter int TIMEOUT_CYC = 500000,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hv_mode,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        err,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_do,
  input  logic              mw_di
);
  localparam int HDR_BITS = 3 + ADDR_W;
  localparam int ALL_BITS = HDR_BITS + DATA_W;
  localparam int LEN_W    = $clog2(ALL_BITS + 1);
  localparam int TMAX     = (GAP_CYC > TIMEOUT_CYC) ? GAP_CYC : TIMEOUT_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam logic [TW-1:0] GAP_LAST = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] TO_LAST  = TW'(TIMEOUT_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_TAIL, S_GAP, S_POLL} st_e;

  st_e                st;
  logic [ALL_BITS-1:0] shreg;
  logic [LEN_W-1:0]   bitpos, nbits_q;
  logic               rd_q, prog_q;
  logic [DATA_W-1:0]  rx;
  logic               cs_q, sk_q, do_q, done_q;
  logic [DATA_W-1:0]  rdata_q;
  mw_err_e            err_q;

  logic [ALL_BITS-1:0] enc_frame;
  logic [LEN_W-1:0]    enc_nbits;
  logic                enc_rd, enc_prog, enc_hv, enc_bad;
  logic                tick;
  logic [TW-1:0]       tcount;
  logic                gap_hit;

  mw_frame_enc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_enc (
    .op(req_op), .addr(req_addr), .wdata(req_wdata),
    .frame(enc_frame), .nbits(enc_nbits), .is_rd(enc_rd),
    .is_prog(enc_prog), .hv_only(enc_hv), .illegal(enc_bad)
  );

  mw_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst),
    .run(st == S_SHIFT || st == S_TAIL),
    .tick(tick)
  );

  assign gap_hit = (st == S_GAP) && (tcount == GAP_LAST);

  mw_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst),
    .en(st == S_GAP || st == S_POLL),
    .clr(gap_hit),
    .count(tcount)
  );

  assign req_ready = (st == S_IDLE) && !done_q;
  assign done  = done_q;
  assign rdata = rdata_q;
  assign err   = err_q;
  assign mw_cs = cs_q;
  assign mw_sk = sk_q;
  assign mw_do = do_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      shreg   <= '0;
      bitpos  <= '0;
      nbits_q <= '0;
      rd_q    <= 1'b0;
      prog_q  <= 1'b0;
      rx      <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      do_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            if (enc_bad || (enc_hv && !hv_mode)) begin
              done_q  <= 1'b1;
              err_q   <= ERR_UNSUP;
              rdata_q <= '0;
            end else begin
              shreg   <= enc_frame;
              nbits_q <= enc_nbits;
              rd_q    <= enc_rd;
              prog_q  <= enc_prog;
              bitpos  <= '0;
              rx      <= '0;
              do_q    <= enc_frame[ALL_BITS-1];
              cs_q    <= 1'b1;
              sk_q    <= 1'b0;
              st      <= S_SHIFT;
            end
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (!sk_q) begin
              sk_q <= 1'b1;
            end else begin
              sk_q <= 1'b0;
              // late-edge capture of read data
              if (rd_q && bitpos >= LEN_W'(HDR_BITS))
                rx <= {rx[DATA_W-2:0], mw_di};
              if (bitpos == nbits_q - 1'b1) begin
                do_q <= 1'b0;
                st   <= S_TAIL;
              end else begin
                bitpos <= bitpos + 1'b1;
                shreg  <= shreg << 1;
                do_q   <= shreg[ALL_BITS-2];
              end
            end
          end
        end
        S_TAIL: begin
          if (tick) begin
            cs_q <= 1'b0;
            if (prog_q) begin
              st <= S_GAP;
            end else begin
              done_q  <= 1'b1;
              err_q   <= ERR_NONE;
              rdata_q <= rd_q ? rx : '0;
              st      <= S_IDLE;
            end
          end
        end
        S_GAP: begin
          if (gap_hit) begin
            cs_q <= 1'b1;
            st   <= S_POLL;
          end
        end
        S_POLL: begin
          if (mw_di || tcount == TO_LAST) begin
            cs_q    <= 1'b0;
            done_q  <= 1'b1;
            err_q   <= mw_di ? ERR_NONE : ERR_TIMEOUT;
            rdata_q <= '0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: clock only toggles while the device is selected
  a_r5_sk_needs_cs: assert property (@(posedge clk) disable iff (rst)
    !mw_cs |-> !mw_sk);
  // R5: data-out holds across the high phase of the clock
  a_r5_do_stable: assert property (@(posedge clk) disable iff (rst)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_do));
  // R9: done lasts exactly one cycle
  a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: an idle controller leaves the bus quiet
  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mw_cs && !mw_sk));
  // R7: select is released whenever completion is reported
  a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
    done |-> !mw_cs);
endmodule

// File: tb/mw_eeprom_ctrl_bench.sv
module mw_eeprom_ctrl_bench;
  localparam int HALF = 4;
  localparam int GAP  = 6;
  localparam int TO   = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic hv = 1'b0;
  logic done;
  logic [7:0] rdata;
  logic [1:0] err;
  logic mw_cs, mw_sk, mw_do, mw_di;

  always #5 clk = ~clk;

  mw_eeprom_ctrl #(.HALF_DIV(HALF), .GAP_CYC(GAP), .TIMEOUT_CYC(TO)) u_mw_eeprom_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .hv_mode(hv),
    .done(done), .rdata(rdata), .err(err),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_do(mw_do), .mw_di(mw_di)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [22:0] exp_frm_q[$];   // {nbits[4:0], value[17:0]}
  logic [9:0]  exp_rsp_q[$];   // {err[1:0], rdata[7:0]}
  int issued = 0;
  int finished = 0;

  // device model
  logic [7:0] mem [128];
  logic [7:0] gold [128];
  int   busy_cyc = 0;
  int   bitcnt = 0, hiw = 0, gapw = 0, pcnt = 0, cs_rises = 0;
  logic [17:0] sh = '0;
  logic [6:0]  ra = '0;
  logic is_rd = 0, rd_bit = 0, poll_win = 0, pending = 0, psk = 0, pcs = 0;

  assign mw_di = poll_win ? (pcnt > busy_cyc) : rd_bit;

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]  = 8'(i) ^ 8'h5A;
      gold[i] = 8'(i) ^ 8'h5A;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mw_sk && !psk && mw_cs && !poll_win) begin
        bitcnt = bitcnt + 1;
        sh = {sh[16:0], mw_do};
        if (bitcnt == 10) begin
          is_rd = (sh[9:7] == 3'b110);
          ra = sh[6:0];
        end
        if (is_rd && bitcnt >= 11 && bitcnt <= 18) rd_bit = mem[ra][18-bitcnt];
      end
      if (mw_sk) hiw++;
      if (!mw_sk && psk) begin
        chk(hiw == HALF, "R6 clock high width", hiw, HALF);
        hiw = 0;
      end
      if (!mw_cs && pcs) begin
        if (poll_win) poll_win = 0;
        else begin
          logic [9:0]  f;
          logic [7:0]  d;
          logic [17:0] val;
          logic [22:0] e;
          val = (bitcnt >= 18) ? sh : (sh & ((18'd1 << bitcnt) - 1));
          if (exp_frm_q.size() == 0) chk(0, "R1 unexpected frame", val, 0);
          else begin
            e = exp_frm_q.pop_front();
            chk(e[22:18] == 5'(bitcnt), "R3 frame length", bitcnt, e[22:18]);
            chk(e[17:0] == val, "R1 R2 frame bits", val, e[17:0]);
          end
          f = (bitcnt == 18) ? sh[17:8] : sh[9:0];
          d = sh[7:0];
          case (f[8:7])
            2'b01: begin mem[f[6:0]] = d; pending = 1; end
            2'b11: begin mem[f[6:0]] = 8'hFF; pending = 1; end
            2'b00: begin
              if (f[6:5] == 2'b10) begin
                for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
                pending = 1;
              end else if (f[6:5] == 2'b01) begin
                for (int i = 0; i < 128; i++) mem[i] = d;
                pending = 1;
              end
            end
            default: ;
          endcase
          gapw = 0;
        end
        bitcnt = 0; sh = '0; is_rd = 0; rd_bit = 0;
      end
      if (mw_cs && !pcs) begin
        cs_rises++;
        if (pending) begin
          chk(gapw >= GAP, "R7 select gap before poll", gapw, GAP);
          pending = 0; poll_win = 1; pcnt = 0;
        end
      end
      if (pending && !mw_cs) gapw++;
      if (poll_win && mw_cs) pcnt++;
      psk = mw_sk; pcs = mw_cs;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_rsp_q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
      else begin
        logic [9:0] r;
        r = exp_rsp_q.pop_front();
        chk(err == r[9:8], "R7 R8 R2 error code", err, r[9:8]);
        chk(rdata == r[7:0], "R4 read data", rdata, r[7:0]);
      end
      finished++;
    end
  end

  function automatic logic [9:0] exp_frame(input logic [2:0] op, input logic [6:0] a);
    case (op)
      3'd0: return 10'h300 | {3'b0, a};
      3'd1: return 10'h280 | {3'b0, a};
      3'd2: return 10'h380 | {3'b0, a};
      3'd3: return 10'h260;
      3'd4: return 10'h200;
      3'd5: return 10'h240;
      3'd6: return 10'h220;
      default: return 10'h000;
    endcase
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic [6:0] a, input logic [7:0] d, input int busy);
    bit unsup, prog, rd, dat;
    logic [1:0] e;
    logic [7:0] rexp;
    int rises0, want;
    unsup = (op == 3'd7) || ((op == 3'd5 || op == 3'd6) && !hv);
    prog  = (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
    rd    = (op == 3'd0);
    dat   = (op == 3'd1 || op == 3'd6);
    rexp  = (rd && !unsup) ? gold[a] : 8'h00;
    if (unsup) e = 2'd2;
    else if (prog && busy >= TO) e = 2'd1;
    else e = 2'd0;
    if (!unsup) begin
      if (rd)       exp_frm_q.push_back({5'd18, exp_frame(op, a), 8'h00});
      else if (dat) exp_frm_q.push_back({5'd18, exp_frame(op, a), d});
      else          exp_frm_q.push_back({5'd10, 8'h00, exp_frame(op, a)});
      case (op)
        3'd1: gold[a] = d;
        3'd2: gold[a] = 8'hFF;
        3'd5: for (int i = 0; i < 128; i++) gold[i] = 8'hFF;
        3'd6: for (int i = 0; i < 128; i++) gold[i] = d;
        default: ;
      endcase
    end
    exp_rsp_q.push_back({e, rexp});
    want = unsup ? 0 : (prog ? 2 : 1);
    busy_cyc = busy;
    rises0 = cs_rises;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    issued++;
    wait (finished == issued);
    @(negedge clk);
    chk(cs_rises - rises0 == want, "R10 R7 R2 select windows", cs_rises - rises0, want);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mw_cs == 1'b0, "R9 reset select", mw_cs, 0);
    chk(mw_sk == 1'b0, "R5 reset clock idle", mw_sk, 0);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    chk(done == 1'b0, "R9 reset done", done, 0);

    run_cmd(3'd3, 7'h00, 8'h00, 0);        // R2 write enable
    run_cmd(3'd1, 7'h03, 8'hA5, 5);        // R3 R7 write
    run_cmd(3'd0, 7'h03, 8'h00, 0);        // R4 R1 read back
    run_cmd(3'd2, 7'h03, 8'h00, 12);       // R1 erase
    run_cmd(3'd0, 7'h03, 8'h00, 0);        // R4 erased byte
    run_cmd(3'd0, 7'h7F, 8'h00, 0);        // R1 top address
    run_cmd(3'd0, 7'h00, 8'h00, 0);        // R4 bottom address
    run_cmd(3'd1, 7'h7F, 8'h81, 0);        // R7 ready at once
    run_cmd(3'd0, 7'h7F, 8'h00, 0);
    run_cmd(3'd4, 7'h00, 8'h00, 0);        // R2 write disable
    hv = 1'b0;
    run_cmd(3'd5, 7'h00, 8'h00, 0);        // R2 erase-all rejected
    run_cmd(3'd6, 7'h00, 8'h77, 0);        // R2 write-all rejected
    run_cmd(3'd7, 7'h11, 8'h00, 0);        // R2 illegal op
    run_cmd(3'd0, 7'h7F, 8'h00, 0);        // R2 array untouched
    hv = 1'b1;
    run_cmd(3'd6, 7'h00, 8'h3C, 20);       // R3 write-all
    run_cmd(3'd0, 7'h00, 8'h00, 0);
    run_cmd(3'd0, 7'h7F, 8'h00, 0);
    run_cmd(3'd5, 7'h00, 8'h00, 8);        // R7 erase-all
    run_cmd(3'd0, 7'h05, 8'h00, 0);
    hv = 1'b0;
    run_cmd(3'd1, 7'h2A, 8'h96, 5000);     // R8 timeout
    run_cmd(3'd0, 7'h2A, 8'h00, 0);
    run_cmd(3'd1, 7'h2B, 8'h01, TO - 10);  // R8 ready just before limit
    run_cmd(3'd0, 7'h2B, 8'h00, 0);

    chk(exp_frm_q.size() == 0, "R1 frames left over", exp_frm_q.size(), 0);
    chk(exp_rsp_q.size() == 0, "R9 responses left over", exp_rsp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule